// File: doc/BRIEF.md
# Dual-Rail Adiabatic Rail Monitor

This block observes one complementary pair of adiabatic rails together with the four-period power clock of the stage that consumes them. Every level arrives as a two-bit code for a three-level waveform (low, ramp, high). The block follows which period the power clock is in, and on each system clock it checks three things. The pair must carry a legal complementary value. The active rail must sit one period ahead of the power clock, a quarter cycle of lead. The logical value must not swap while the power clock is on a ramp.

Findings go out three ways. A three-bit status code names the most serious finding of the latest sample. A sticky flag word keeps one bit per class of finding until reset or a clear pulse. A one-cycle pulse marks each new finding. The monitor sits next to a modelled adiabatic stage and is used during verification runs to catch lead and lag errors early. It takes no part in the stage's logic.

Top module: `adiabatic_rail_monitor`

## Requirements
- R1: The power clock and both rails use the same level code: 00 is low, 01 is ramp, and 10 or 11 is high. The power-clock period is Idle when the clock is low and Hold when it is high. A ramp that follows low is Evaluate. A ramp that follows high is Recover. A ramp seen before any plateau since reset counts as Recover.
- R2: When both rails are non-low at the same time, in any period, status is 2 and flag bit 1 is set.
- R3: When both rails are low while the power clock is in Idle, Evaluate or Hold, status is 1 and flag bit 0 is set. Both rails low during Recover is legal.
- R4: When exactly one rail is non-low, it must be at ramp during Idle, at high during Evaluate, and at ramp during Hold. Any non-low rail during Recover is wrong. A breach of any of these gives status 3 and sets flag bit 2.
- R5: During Evaluate or Recover, if exactly one rail is non-low in two consecutive samples and it is not the same rail both times, status is 4 and flag bit 3 is set.
- R6: When several classes occur in one sample, status reports the first of this order: 2, 1, 4, 3. The flag bit of every class found is set. A sample with no finding gives status 0.
- R7: Status, flags and pulse show the inputs sampled at the previous rising clock edge. There is exactly one register stage.
- R8: A flag bit stays set until reset or a clear. A clear in a given cycle empties the word except for the classes found in that same cycle's sample.
- R9: The pulse is high for one cycle when the new status is nonzero and differs from the previous status. It stays low while the same nonzero code repeats.
- R10: While reset is asserted, status, flags and pulse are all zero. The reset acts asynchronously and is released on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Clears the sticky flag word |
| pc_lvl | input | 2 | Level code of the consuming power clock |
| rail_t | input | 2 | Level code of the true rail |
| rail_f | input | 2 | Level code of the complement rail |
| err_flags | output | 4 | Sticky flags: bit0 both low, bit1 both high, bit2 phase, bit3 swap on ramp |
| err_pulse | output | 1 | One-cycle marker of a new finding |
| status | output | 3 | Code of the most serious finding of the last sample |

## Verification
The hardest finding to reach is a swap on a ramp that also breaks the phase rule. To create it, the power clock must first be on its rising ramp after an Idle plateau. The true rail must already be settled high. Then, in the next sample, the complement rail takes over while it is still ramping. The directed sequences first walk the power clock through full legal periods, so that the Evaluate and Recover ramps are told apart by the plateau before them. Only then do they inject the swapped or late rail, and they check both the reported code and the two flag bits. Clears issued in the same cycle as a new finding are used to show that the new finding survives the clear.

// File: rtl/adb_mon_pkg.sv
package adb_mon_pkg;

  localparam int LVL_W  = 2;
  localparam int CODE_W = 3;
  localparam int NCLS   = 4;

  typedef enum logic [1:0] {LV_LOW, LV_RAMP, LV_HIGH} lvl_e;

  typedef enum logic [1:0] {PH_IDLE, PH_EVAL, PH_HOLD, PH_RECOV} phase_e;

  typedef enum logic [CODE_W-1:0] {
    ST_OK      = 3'd0,
    ST_BOTH_LO = 3'd1,
    ST_BOTH_HI = 3'd2,
    ST_PHASE   = 3'd3,
    ST_RAMPCHG = 3'd4
  } status_e;

  // packed order gives flag bit0 = both_lo ... bit3 = rampchg
  typedef struct packed {
    logic rampchg;
    logic phase;
    logic both_hi;
    logic both_lo;
  } viol_t;

  function automatic lvl_e decode_lvl(input logic [LVL_W-1:0] raw);
    if (raw[1])      return LV_HIGH;
    else if (raw[0]) return LV_RAMP;
    else             return LV_LOW;
  endfunction

endpackage

// File: rtl/adb_phase_track.sv
module adb_phase_track
  import adb_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] pc_raw,
  output phase_e           phase
);

  lvl_e pc_lvl;
  logic plat_hi_q;
  logic plat_hi_d;
  logic plat_en;

  always_comb begin
    pc_lvl    = decode_lvl(pc_raw);
    plat_en   = (pc_lvl != LV_RAMP);
    plat_hi_d = (pc_lvl == LV_HIGH);
    unique case (pc_lvl)
      LV_LOW:  phase = PH_IDLE;
      LV_HIGH: phase = PH_HOLD;
      default: phase = plat_hi_q ? PH_RECOV : PH_EVAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       plat_hi_q <= 1'b1;
    else if (plat_en) plat_hi_q <= plat_hi_d;
  end

endmodule

// File: rtl/adb_rail_check.sv
module adb_rail_check
  import adb_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic [LVL_W-1:0] t_raw,
  input  logic [LVL_W-1:0] f_raw,
  output viol_t            viol
);

  lvl_e t_lvl, f_lvl, act_lvl, exp_lvl;
  logic t_act, f_act, single;
  logic prev_single_q, prev_t_q;
  logic on_ramp;

  always_comb begin
    t_lvl   = decode_lvl(t_raw);
    f_lvl   = decode_lvl(f_raw);
    t_act   = (t_lvl != LV_LOW);
    f_act   = (f_lvl != LV_LOW);
    single  = t_act ^ f_act;
    act_lvl = t_act ? t_lvl : f_lvl;
    on_ramp = (phase == PH_EVAL) || (phase == PH_RECOV);
    unique case (phase)
      PH_IDLE: exp_lvl = LV_RAMP;
      PH_EVAL: exp_lvl = LV_HIGH;
      PH_HOLD: exp_lvl = LV_RAMP;
      default: exp_lvl = LV_LOW;
    endcase

    viol.both_hi = t_act && f_act;
    viol.both_lo = !t_act && !f_act && (phase != PH_RECOV);
    viol.phase   = single && (act_lvl != exp_lvl);
    viol.rampchg = on_ramp && single && prev_single_q && (t_act != prev_t_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_single_q <= 1'b0;
      prev_t_q      <= 1'b0;
    end else begin
      prev_single_q <= single;
      prev_t_q      <= t_act;
    end
  end

endmodule

// File: rtl/adb_err_report.sv
module adb_err_report
  import adb_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  viol_t             viol,
  output logic [NCLS-1:0]   flags,
  output logic              pulse,
  output logic [CODE_W-1:0] code
);

  status_e         code_d, code_q;
  logic [NCLS-1:0] flags_d, flags_q;
  logic            pulse_d, pulse_q;

  always_comb begin
    if (viol.both_hi)      code_d = ST_BOTH_HI;
    else if (viol.both_lo) code_d = ST_BOTH_LO;
    else if (viol.rampchg) code_d = ST_RAMPCHG;
    else if (viol.phase)   code_d = ST_PHASE;
    else                   code_d = ST_OK;
    flags_d = (clr ? '0 : flags_q) | NCLS'(viol);
    pulse_d = (code_d != ST_OK) && (code_d != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= ST_OK;
      flags_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      flags_q <= flags_d;
      pulse_q <= pulse_d;
    end
  end

  assign flags = flags_q;
  assign pulse = pulse_q;
  assign code  = code_q;

endmodule

// File: rtl/adb_rst_sync.sv
module adb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/adiabatic_rail_monitor.sv
module adiabatic_rail_monitor
  import adb_mon_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [LVL_W-1:0]  pc_lvl,
  input  logic [LVL_W-1:0]  rail_t,
  input  logic [LVL_W-1:0]  rail_f,
  output logic [NCLS-1:0]   err_flags,
  output logic              err_pulse,
  output logic [CODE_W-1:0] status
);

  logic   rst_sync_n;
  phase_e phase;
  viol_t  viol;

  adb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adb_phase_track u_phase (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pc_raw (pc_lvl),
    .phase  (phase)
  );

  adb_rail_check u_check (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .phase (phase),
    .t_raw (rail_t),
    .f_raw (rail_f),
    .viol  (viol)
  );

  adb_err_report u_report (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clr),
    .viol  (viol),
    .flags (err_flags),
    .pulse (err_pulse),
    .code  (status)
  );

endmodule

// File: rtl/adiabatic_rail_monitor_chk.sv
module adiabatic_rail_monitor_chk
  import adb_mon_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic [LVL_W-1:0]  rail_t,
  input logic [LVL_W-1:0]  rail_f,
  input logic [NCLS-1:0]   err_flags,
  input logic              err_pulse,
  input logic [CODE_W-1:0] status
);

  p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status <= CODE_W'(ST_RAMPCHG));

  p_both_hi_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rail_t != '0) && (rail_f != '0)) |=> (status == CODE_W'(ST_BOTH_HI)));

  p_sticky_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  p_pulse_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (status != '0));

  p_pulse_new_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (status != $past(status)));

  p_code_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status != '0) |-> (err_flags != '0));

endmodule

bind adiabatic_rail_monitor adiabatic_rail_monitor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .clr       (clr),
  .rail_t    (rail_t),
  .rail_f    (rail_f),
  .err_flags (err_flags),
  .err_pulse (err_pulse),
  .status    (status)
);

// File: tb/test_adiabatic_rail_monitor.sv
`timescale 1ns/1ps
module test_adiabatic_rail_monitor;

  localparam logic [1:0] L = 2'b00;
  localparam logic [1:0] M = 2'b01;
  localparam logic [1:0] H = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr;
  logic [1:0] pc_lvl, rail_t, rail_f;
  logic [3:0] err_flags;
  logic       err_pulse;
  logic [2:0] status;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  adiabatic_rail_monitor i_adiabatic_rail_monitor (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .pc_lvl    (pc_lvl),
    .rail_t    (rail_t),
    .rail_f    (rail_f),
    .err_flags (err_flags),
    .err_pulse (err_pulse),
    .status    (status)
  );

  task automatic expect_out(input logic [2:0] e_code, input logic [3:0] e_flags,
                            input logic e_pulse, input string req);
    total++;
    if (status !== e_code || err_flags !== e_flags || err_pulse !== e_pulse) begin
      bad++;
      $display("FAIL %s: status=%0d flags=%b pulse=%b expected status=%0d flags=%b pulse=%b",
               req, status, err_flags, err_pulse, e_code, e_flags, e_pulse);
    end
  endtask

  // drive at a falling edge, outputs are read at the next falling edge (R7)
  task automatic drive(input logic [1:0] pc, input logic [1:0] t, input logic [1:0] f,
                       input logic c = 1'b0);
    pc_lvl = pc; rail_t = t; rail_f = f; clr = c;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clr = 1'b0; pc_lvl = L; rail_t = M; rail_f = L;
    repeat (3) @(negedge clk);
    expect_out(3'd0, 4'b0000, 1'b0, "R10 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_out(3'd0, 4'b0000, 1'b0, "R10 after release");
  endtask

  task automatic t_legal();
    drive(L, M, L); expect_out(0, 4'b0000, 0, "R4 true idle");
    drive(M, H, L); expect_out(0, 4'b0000, 0, "R4 true eval");
    drive(H, M, L); expect_out(0, 4'b0000, 0, "R4 true hold");
    drive(M, L, L); expect_out(0, 4'b0000, 0, "R3 both low in recover ok");
    drive(L, L, M); expect_out(0, 4'b0000, 0, "R4 false idle");
    drive(M, L, H); expect_out(0, 4'b0000, 0, "R1 false eval");
    drive(2'b11, L, 2'b01); expect_out(0, 4'b0000, 0, "R1 code 11 is high");
    drive(M, L, L); expect_out(0, 4'b0000, 0, "R1 ramp after high is recover");
  endtask

  task automatic t_both_high();
    drive(L, M, L); expect_out(0, 4'b0000, 0, "R2 setup");
    drive(M, H, H); expect_out(2, 4'b0010, 1, "R2 both high");
    drive(M, H, 2'b11); expect_out(2, 4'b0010, 0, "R9 repeat no pulse");
    drive(H, M, L); expect_out(0, 4'b0010, 0, "R8 flag kept");
    drive(M, L, L); expect_out(0, 4'b0010, 0, "R8 flag kept recover");
  endtask

  task automatic t_clear();
    drive(L, M, L, 1'b1); expect_out(0, 4'b0000, 0, "R8 clear");
    drive(M, L, L);       expect_out(1, 4'b0001, 1, "R3 both low in eval");
    drive(M, H, H, 1'b1); expect_out(2, 4'b0010, 1, "R8 clear keeps same-cycle class");
    drive(H, M, L, 1'b1); expect_out(0, 4'b0000, 0, "R8 clear to zero");
    drive(M, L, L);       expect_out(0, 4'b0000, 0, "R3 recover ok");
    drive(L, L, L);       expect_out(1, 4'b0001, 1, "R3 both low in idle");
    drive(L, M, L, 1'b1); expect_out(0, 4'b0000, 0, "R8 clear");
  endtask

  task automatic t_phase();
    drive(M, M, L); expect_out(3, 4'b0100, 1, "R4 still ramping in eval");
    drive(H, M, L); expect_out(0, 4'b0100, 0, "R4 hold ok");
    drive(M, H, L); expect_out(3, 4'b0100, 1, "R4 late high in recover");
    drive(L, H, L); expect_out(3, 4'b0100, 0, "R4 high in idle repeats code");
    drive(L, M, L, 1'b1); expect_out(0, 4'b0000, 0, "R8 clear");
  endtask

  task automatic t_ramp_swap();
    drive(M, H, L); expect_out(0, 4'b0000, 0, "R5 eval ok");
    drive(M, L, H); expect_out(4, 4'b1000, 1, "R5 swap during eval");
    drive(H, L, M); expect_out(0, 4'b1000, 0, "R5 hold ok");
    drive(M, L, L); expect_out(0, 4'b1000, 0, "R5 recover ok");
    drive(L, M, L, 1'b1); expect_out(0, 4'b0000, 0, "R8 clear");
  endtask

  task automatic t_priority();
    drive(M, H, L); expect_out(0, 4'b0000, 0, "R6 eval ok");
    drive(M, L, M); expect_out(4, 4'b1100, 1, "R6 swap beats phase");
    drive(M, L, M); expect_out(3, 4'b1100, 1, "R9 pulse on code change");
    drive(H, L, M); expect_out(0, 4'b1100, 0, "R6 back to ok");
  endtask

  initial begin
    t_reset();
    t_legal();
    t_both_high();
    t_clear();
    t_phase();
    t_ramp_swap();
    t_priority();
    rst_n = 1'b0;
    #1;
    expect_out(0, 4'b0000, 0, "R10 async reset");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule